// File: doc/BRIEF.md
# Stream-Cipher Keystream Block Core

This core turns a 256-bit key and four 32-bit counter/nonce words into one 64-byte keystream block of the ChaCha20 stream cipher. It builds a sixteen-word working state with the four fixed cipher constants. It then runs ten double rounds on that state, one quarter-round per clock. Finally it adds the starting state back into the result, word by word, and presents the 512-bit block.

A caller presents the key and the counter/nonce words and pulses `start`. The core samples its inputs on that edge and runs by itself. It raises `done` for a single cycle when the block is ready. Beside the block it reports the block counter plus one, which the caller feeds back for the next block. The block and the counter value stay on the outputs until the next run completes. XOR with data, message length handling and subkey derivation belong to the surrounding logic.

Top module: `chacha_block_core`

## Requirements
- R1: Each quarter-round on words (a,b,c,d) runs these steps in order, with every addition taken modulo 2^32: a+=b, d=rotl(d^a,16), c+=d, b=rotl(b^c,12), a+=b, d=rotl(d^a,8), c+=d, b=rotl(b^c,7).
- R2: The working state holds 16 words, and word 4i+j sits at row i, column j. Words 0..3 are the constants 0x61707865, 0x3320646e, 0x79622d32, 0x6b206574. Word 4+k is `keyIn[32k+31:32k]` for k=0..7. Word 12+j is `ctrNonceIn[32j+31:32j]` for j=0..3.
- R3: One double round is four column quarter-rounds, on (0,4,8,12), (1,5,9,13), (2,6,10,14) and (3,7,11,15). These are followed by four diagonal quarter-rounds, on (0,5,10,15), (1,6,11,12), (2,7,8,13) and (3,4,9,14). Ten double rounds are applied.
- R4: Each output word is the final working word plus the matching starting word, modulo 2^32.
- R5: Output word i appears at `keyStream[32i+31:32i]`, so byte n of the block is `keyStream[8n+7:8n]` (little-endian).
- R6: When `start` is sampled while the core is idle, `done` goes high exactly 81 clock edges later, and only for one cycle.
- R7: When `done` rises, `nextCounter` equals `ctrNonceIn[31:0]` plus one, modulo 2^32, as sampled at start.
- R8: A `start` pulse that arrives while a block is being computed has no effect. The running block and its completion time are unchanged.
- R9: `keyStream` and `nextCounter` hold their values until the next block completes, even when the inputs change.
- R10: After reset, `done` is 0 and `keyStream` and `nextCounter` are all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a block; sampled only when the core is idle |
| keyIn | input | 256 | Key, eight 32-bit words, word 0 at the low bits |
| ctrNonceIn | input | 128 | Block counter (low word) and three nonce words |
| done | output | 1 | One-cycle pulse when the block is ready |
| keyStream | output | 512 | Keystream block, word 0 / byte 0 at the low bits |
| nextCounter | output | 32 | Sampled counter word plus one |

## Verification
Each block is compared in full with a bench model that runs the quarter-rounds through loop-derived index sets, not through a case table. A fixed-key vector with a known first output word confirms the constants, the word layout and the byte order, which a self-consistent but wrongly ordered design would otherwise pass. Seeded random keys and nonces exercise every rotation and carry path. Directed all-zero inputs and an all-ones counter check the feed-forward and the counter wrap. A second start issued mid-run, and input changes made after completion, show that the running block and the held outputs cannot be disturbed.

// File: rtl/chacha_pkg.sv
package chacha_pkg;
  localparam int WORD_W  = 32;
  localparam int N_WORDS = 16;
  localparam int QR_PER_DBL = 8;

  typedef logic [WORD_W-1:0] word_t;
  typedef word_t [N_WORDS-1:0] state_t;

  typedef struct packed {
    logic       load;
    logic       qrEn;
    logic [2:0] qrSel;
    logic       finish;
  } ctrlStrobe_t;

  localparam logic [4*WORD_W-1:0] SIGMA = {32'h6b206574, 32'h79622d32,
                                           32'h3320646e, 32'h61707865};

  function automatic word_t rotl(input word_t v, input int n);
    return (v << n) | (v >> (WORD_W - n));
  endfunction
endpackage

// File: rtl/chacha_qround.sv
module chacha_qround
  import chacha_pkg::*;
(
  input  word_t aIn,
  input  word_t bIn,
  input  word_t cIn,
  input  word_t dIn,
  output word_t aOut,
  output word_t bOut,
  output word_t cOut,
  output word_t dOut
);
  word_t a1, d1, c1, b1, a2, d2, c2;

  always_comb begin
    a1 = aIn + bIn;
    d1 = rotl(dIn ^ a1, 16);
    c1 = cIn + d1;
    b1 = rotl(bIn ^ c1, 12);
    a2 = a1 + b1;
    d2 = rotl(d1 ^ a2, 8);
    c2 = c1 + d2;
    aOut = a2;
    dOut = d2;
    cOut = c2;
    bOut = rotl(b1 ^ c2, 7);
  end
endmodule

// File: rtl/chacha_ctrl.sv
module chacha_ctrl
  import chacha_pkg::*;
#(
  parameter int DOUBLE_ROUNDS = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output ctrlStrobe_t strobes,
  output logic        done
);
  localparam int TOTAL_QR = DOUBLE_ROUNDS * QR_PER_DBL;
  localparam int CNT_W    = $clog2(TOTAL_QR);
  localparam logic [CNT_W-1:0] LAST_QR = CNT_W'(TOTAL_QR - 1);

  typedef enum logic [1:0] {S_IDLE, S_ROUND, S_FINAL} phase_t;

  phase_t         phase, phaseNext;
  logic [CNT_W-1:0] qrCnt;

  always_comb begin
    strobes   = '0;
    phaseNext = phase;
    unique case (phase)
      S_IDLE: if (start) begin
        strobes.load = 1'b1;
        phaseNext    = S_ROUND;
      end
      S_ROUND: begin
        strobes.qrEn  = 1'b1;
        strobes.qrSel = qrCnt[2:0];
        if (qrCnt == LAST_QR) phaseNext = S_FINAL;
      end
      S_FINAL: begin
        strobes.finish = 1'b1;
        phaseNext      = S_IDLE;
      end
      default: phaseNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= S_IDLE;
      qrCnt <= '0;
      done  <= 1'b0;
    end else begin
      phase <= phaseNext;
      done  <= strobes.finish;
      if (strobes.load)      qrCnt <= '0;
      else if (strobes.qrEn) qrCnt <= qrCnt + 1'b1;
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3
  qr_count_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == S_ROUND) |-> (qrCnt <= LAST_QR));

  // R8
  idle_after_final_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.finish |=> !strobes.qrEn);
endmodule

// File: rtl/chacha_datapath.sv
module chacha_datapath
  import chacha_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobes,
  input  logic [8*WORD_W-1:0]  keyIn,
  input  logic [4*WORD_W-1:0]  ctrNonceIn,
  output logic [N_WORDS*WORD_W-1:0] keyStream,
  output word_t                nextCounter
);
  state_t workReg, origReg, initState, sumState;
  logic [3:0] ia, ib, ic, id;
  word_t qa, qb, qc, qd;

  assign initState = {ctrNonceIn, keyIn, SIGMA};

  always_comb begin
    unique case (strobes.qrSel)
      3'd0: {ia, ib, ic, id} = {4'd0, 4'd4, 4'd8,  4'd12};
      3'd1: {ia, ib, ic, id} = {4'd1, 4'd5, 4'd9,  4'd13};
      3'd2: {ia, ib, ic, id} = {4'd2, 4'd6, 4'd10, 4'd14};
      3'd3: {ia, ib, ic, id} = {4'd3, 4'd7, 4'd11, 4'd15};
      3'd4: {ia, ib, ic, id} = {4'd0, 4'd5, 4'd10, 4'd15};
      3'd5: {ia, ib, ic, id} = {4'd1, 4'd6, 4'd11, 4'd12};
      3'd6: {ia, ib, ic, id} = {4'd2, 4'd7, 4'd8,  4'd13};
      default: {ia, ib, ic, id} = {4'd3, 4'd4, 4'd9, 4'd14};
    endcase
  end

  chacha_qround qrUnit (
    .aIn(workReg[ia]), .bIn(workReg[ib]), .cIn(workReg[ic]), .dIn(workReg[id]),
    .aOut(qa), .bOut(qb), .cOut(qc), .dOut(qd)
  );

  for (genvar w = 0; w < N_WORDS; w++) begin : g_ff
    assign sumState[w] = workReg[w] + origReg[w];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      workReg     <= '0;
      origReg     <= '0;
      keyStream   <= '0;
      nextCounter <= '0;
    end else begin
      if (strobes.load) begin
        workReg <= initState;
        origReg <= initState;
      end else if (strobes.qrEn) begin
        workReg[ia] <= qa;
        workReg[ib] <= qb;
        workReg[ic] <= qc;
        workReg[id] <= qd;
      end
      if (strobes.finish) begin
        keyStream   <= sumState;
        nextCounter <= origReg[12] + 1'b1;
      end
    end
  end

  // R9
  held_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.finish |=> ($stable(keyStream) && $stable(nextCounter)));

  // R8
  orig_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(origReg));
endmodule

// File: rtl/chacha_block_core.sv
module chacha_block_core
  import chacha_pkg::*;
#(
  parameter int DOUBLE_ROUNDS = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [255:0] keyIn,
  input  logic [127:0] ctrNonceIn,
  output logic         done,
  output logic [511:0] keyStream,
  output logic [31:0]  nextCounter
);
  ctrlStrobe_t strobes;

  chacha_ctrl #(.DOUBLE_ROUNDS(DOUBLE_ROUNDS)) ctrlUnit (
    .clk(clk), .rstN(rstN), .start(start), .strobes(strobes), .done(done)
  );

  chacha_datapath dpUnit (
    .clk(clk), .rstN(rstN), .strobes(strobes), .keyIn(keyIn),
    .ctrNonceIn(ctrNonceIn), .keyStream(keyStream), .nextCounter(nextCounter)
  );
endmodule

// File: tb/chacha_block_core_test.sv
module chacha_block_core_test;
  logic         clk = 0;
  logic         rstN = 0;
  logic         start = 0;
  logic [255:0] keyIn = '0;
  logic [127:0] ctrNonceIn = '0;
  logic         done;
  logic [511:0] keyStream;
  logic [31:0]  nextCounter;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  chacha_block_core uut (.*);

  always #5 clk = ~clk;

  function automatic logic [31:0] rl(input logic [31:0] v, input int n);
    return (v << n) | (v >> (32 - n));
  endfunction

  function automatic logic [511:0] refBlock(input logic [255:0] k, input logic [127:0] cn);
    logic [31:0] s[16];
    logic [31:0] x[16];
    logic [511:0] r;
    int q[4];
    s[0] = 32'h61707865; s[1] = 32'h3320646e; s[2] = 32'h79622d32; s[3] = 32'h6b206574;
    for (int i = 0; i < 8; i++) s[4+i] = k[32*i +: 32];
    for (int i = 0; i < 4; i++) s[12+i] = cn[32*i +: 32];
    for (int i = 0; i < 16; i++) x[i] = s[i];
    for (int dr = 0; dr < 10; dr++) begin
      for (int pass = 0; pass < 2; pass++) begin
        for (int col = 0; col < 4; col++) begin
          for (int row = 0; row < 4; row++)
            q[row] = 4*row + ((col + pass*row) % 4);
          x[q[0]] += x[q[1]]; x[q[3]] = rl(x[q[3]] ^ x[q[0]], 16);
          x[q[2]] += x[q[3]]; x[q[1]] = rl(x[q[1]] ^ x[q[2]], 12);
          x[q[0]] += x[q[1]]; x[q[3]] = rl(x[q[3]] ^ x[q[0]], 8);
          x[q[2]] += x[q[3]]; x[q[1]] = rl(x[q[1]] ^ x[q[2]], 7);
        end
      end
    end
    for (int i = 0; i < 16; i++) r[32*i +: 32] = x[i] + s[i];
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Runs one block; optional second start midRun cycles into the run.
  task automatic runBlock(input logic [255:0] k, input logic [127:0] cn, input int midRun,
                          input string tag);
    int lat = 0;
    logic [511:0] exp = refBlock(k, cn);
    @(negedge clk);
    keyIn = k; ctrNonceIn = cn; start = 1;
    @(negedge clk);
    start = 0;
    while (!done && lat < 300) begin
      @(negedge clk);
      lat++;
      if (midRun > 0 && lat == midRun) begin
        keyIn = ~k; ctrNonceIn = ~cn; start = 1;
        @(negedge clk); lat++;
        start = 0;
      end
    end
    // R6 latency of 81 edges from the start edge
    check(lat == 81, {tag, " R6 latency"}, 512'(lat), 512'd81);
    // R1 R3 R4 R5 block value
    check(keyStream == exp, {tag, " R1/R3/R4/R5 block"}, keyStream, exp);
    // R7 counter plus one
    check(nextCounter == cn[31:0] + 32'd1, {tag, " R7 nextCounter"},
          512'(nextCounter), 512'(cn[31:0] + 32'd1));
    @(negedge clk);
    check(done == 1'b0, {tag, " R6 one-cycle done"}, 512'(done), 512'd0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [255:0] k;
    logic [127:0] cn;
    logic [511:0] held;
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    // R10 reset state
    check(done == 0 && keyStream == '0 && nextCounter == '0, "R10 reset state",
          keyStream, '0);
    rstN = 1;
    @(negedge clk);

    // R2 R5 known vector: key bytes 0..31, counter 1, fixed nonce
    for (int i = 0; i < 32; i++) k[8*i +: 8] = 8'(i);
    cn = {32'h00000000, 32'h4a000000, 32'h09000000, 32'h00000001};
    runBlock(k, cn, 0, "known");
    check(keyStream[31:0] == 32'he4e7f110, "R2/R5 known word0",
          512'(keyStream[31:0]), 512'h e4e7f110);
    check(keyStream[7:0] == 8'h10, "R5 byte0 little-endian",
          512'(keyStream[7:0]), 512'h10);

    // R4 all-zero inputs, R7 counter wrap
    runBlock('0, '0, 0, "zero");
    runBlock({8{32'hffffffff}}, {96'h0, 32'hffffffff}, 0, "wrap");
    check(nextCounter == 32'd0, "R7 wrap to zero", 512'(nextCounter), 512'd0);

    // R8 start while busy ignored
    k = {8{$urandom()}}; cn = {$urandom(), $urandom(), $urandom(), $urandom()};
    runBlock(k, cn, 20, "midstart");

    // R9 held outputs while inputs change
    held = keyStream;
    keyIn = ~keyIn; ctrNonceIn = ~ctrNonceIn;
    repeat (30) @(negedge clk);
    check(keyStream == held && done == 0, "R9 outputs held", keyStream, held);

    // random blocks
    for (int t = 0; t < 12; t++) begin
      for (int w = 0; w < 8; w++) k[32*w +: 32] = $urandom();
      for (int w = 0; w < 4; w++) cn[32*w +: 32] = $urandom();
      runBlock(k, cn, 0, "random");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule